// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a serial-bus slave that gives a host access to a bank of 8-bit configuration registers. The bus lines SCL and SDA are sampled by the system clock. SDA is open-drain: the block only ever pulls it low. Transfers are indexed block transfers. A write carries a starting index, a byte count and then that many data bytes. A read first places the index with a short write, then reissues a start with the read address.

Toward the clock-control logic the block has a one-cycle write strobe with an index and data, and a read index with a returned data byte. The block keeps one register itself: the readback length register at index 8. That register sets how many data bytes a read returns. A read always sends this length first and then the register contents.

Top module: `idx_i2c_regslave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte is not acknowledged, and the rest of that transaction is ignored until the next start.
- R2: After 0xD2 the slave acknowledges a start index N, then a count X, then X data bytes. Data byte k (k = 0..X-1) produces exactly one single-cycle write strobe at index N+k carrying that byte.
- R3: In a write, data bytes after the X counted ones are not acknowledged and produce no write strobe.
- R4: After a repeated start and 0xD3, the slave sends the current readback length first. It then sends the registers from the current index upward, one per byte, most significant bit first.
- R5: A not-acknowledge from the master ends the read. The slave releases SDA and returns to idle at the following stop.
- R6: The readback length register sits at index 8 and resets to 0x0F. A write to index 8 loads it and is not forwarded on the write port. Reading index 8 returns it, and it sets how many data bytes follow the length byte in a read.
- R7: Indices at or above NUM_REGS (default 24) produce no write strobe and read back as 0x00.
- R8: A start or stop at any point aborts the transaction and releases SDA. Bytes written before the abort are kept.
- R9: If the master acknowledges the last counted read byte, the slave stops driving SDA (the master reads 0xFF) until the next stop or start.
- R10: The slave changes what it drives on SDA only while the sampled SCL is low, apart from the release forced by a start or stop.
- R11: During and after reset, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_waddr | output | IDX_W | Index of the register being written |
| reg_wdata | output | 8 | Data for the register being written |
| reg_raddr | output | IDX_W | Index of the register to be read |
| reg_rdata | input | 8 | Register content at reg_raddr |

## Verification
The assertions check on every cycle that the write strobe lasts one cycle and never targets an out-of-range index or the length register. They also check that SDA is released after any start or stop, that SDA drive changes only with SCL low, and that nothing is driven out of reset. The bench's scenarios are needed for the byte-level protocol: address filtering, the length byte that leads a read, an index that keeps advancing across a transfer, rejection of surplus write bytes, zero readback past the bank, release after an acknowledged final byte, and the survival of register contents across an aborted transfer.

// File: rtl/ibrs_pkg.sv
package ibrs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a start
    S_RX,     // shifting in a byte
    S_RXEND,  // byte received, waiting for SCL low to answer
    S_ACK,    // holding acknowledge low
    S_TX,     // shifting out a byte
    S_ACKIN,  // sampling the master's acknowledge
    S_LOAD,   // fetch next read byte at SCL low
    S_HOLD    // released, waiting for stop or start
  } state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_INDEX,
    K_COUNT,
    K_DATA
  } kind_t;
endpackage

// File: rtl/ibrs_line_sync.sv
module ibrs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges with the clock held high mark frame boundaries
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ibrs_rd_sel.sv
module ibrs_rd_sel #(
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 24,
  parameter int CNT_IDX  = 8
) (
  input  logic [IDX_W-1:0] ptr,
  input  logic [7:0]       cnt,
  input  logic [7:0]       ext_data,
  output logic [7:0]       rd_byte
);
  always_comb begin
    if (32'(ptr) == CNT_IDX)      rd_byte = cnt;
    else if (32'(ptr) < NUM_REGS) rd_byte = ext_data;
    else                          rd_byte = 8'h00;
  end
endmodule

// File: rtl/ibrs_fsm.sv
module ibrs_fsm
  import ibrs_pkg::*;
#(
  parameter int         IDX_W    = 8,
  parameter int         NUM_REGS = 24,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] CNT_RST  = 8'h0F,
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter logic [7:0] RD_ADDR  = 8'hD3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic             sda_oe,
  output logic [IDX_W-1:0] ptr,
  output logic [7:0]       cnt,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_waddr,
  output logic [7:0]       reg_wdata
);
  state_t     state;
  kind_t      kind;
  logic       rd_mode, ack_pend, tx_is_cnt;
  logic [2:0] bit_cnt;
  logic [7:0] shreg, txsh, wr_rem, rd_rem;
  logic [7:0] nb;

  assign nb = {shreg[6:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind      <= K_ADDR;
      rd_mode   <= 1'b0;
      ack_pend  <= 1'b0;
      tx_is_cnt <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      txsh      <= '0;
      wr_rem    <= '0;
      rd_rem    <= '0;
      ptr       <= '0;
      cnt       <= CNT_RST;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state   <= S_RX;
        kind    <= K_ADDR;
        rd_mode <= 1'b0;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state)
          S_RX: if (scl_rise) begin
            shreg   <= nb;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              state    <= S_RXEND;
              ack_pend <= 1'b0;
              unique case (kind)
                K_ADDR: begin
                  if (nb == WR_ADDR) begin
                    ack_pend <= 1'b1;
                    kind     <= K_INDEX;
                  end else if (nb == RD_ADDR) begin
                    ack_pend <= 1'b1;
                    rd_mode  <= 1'b1;
                  end
                end
                K_INDEX: begin
                  ptr      <= IDX_W'(nb);
                  kind     <= K_COUNT;
                  ack_pend <= 1'b1;
                end
                K_COUNT: begin
                  wr_rem   <= nb;
                  kind     <= K_DATA;
                  ack_pend <= 1'b1;
                end
                K_DATA: begin
                  if (wr_rem != 8'd0) begin
                    ack_pend <= 1'b1;
                    wr_rem   <= wr_rem - 8'd1;
                    ptr      <= ptr + 1'b1;
                    if (32'(ptr) == CNT_IDX) begin
                      cnt <= nb;
                    end else if (32'(ptr) < NUM_REGS) begin
                      reg_we    <= 1'b1;
                      reg_waddr <= ptr;
                      reg_wdata <= nb;
                    end
                  end
                end
                default: ;
              endcase
            end
          end
          S_RXEND: if (scl_fall) begin
            if (ack_pend) begin
              sda_oe <= 1'b1;
              state  <= S_ACK;
            end else begin
              state  <= S_IDLE;
            end
          end
          S_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              txsh      <= cnt;
              sda_oe    <= ~cnt[7];
              tx_is_cnt <= 1'b1;
              rd_rem    <= cnt;
              state     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= S_ACKIN;
            end else begin
              txsh    <= {txsh[6:0], 1'b0};
              sda_oe  <= ~txsh[6];
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
          S_ACKIN: if (scl_rise) begin
            if (sda_s) begin
              state <= S_HOLD;
            end else if (tx_is_cnt) begin
              tx_is_cnt <= 1'b0;
              state     <= (rd_rem == 8'd0) ? S_HOLD : S_LOAD;
            end else begin
              ptr    <= ptr + 1'b1;
              rd_rem <= rd_rem - 8'd1;
              state  <= (rd_rem == 8'd1) ? S_HOLD : S_LOAD;
            end
          end
          S_LOAD: if (scl_fall) begin
            txsh    <= rd_byte;
            sda_oe  <= ~rd_byte[7];
            bit_cnt <= '0;
            state   <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idx_i2c_regslave.sv
module idx_i2c_regslave #(
  parameter int         IDX_W       = 8,
  parameter int         NUM_REGS    = 24,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CNT_RST     = 8'h0F,
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_waddr,
  output logic [7:0]       reg_wdata,
  output logic [IDX_W-1:0] reg_raddr,
  input  logic [7:0]       reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDX_W-1:0] ptr;
  logic [7:0] cnt, rd_byte;

  ibrs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ibrs_rd_sel #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX)) u_rsel (
    .ptr(ptr), .cnt(cnt), .ext_data(reg_rdata), .rd_byte(rd_byte)
  );

  ibrs_fsm #(
    .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST),
    .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .ptr(ptr), .cnt(cnt),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
  );

  assign reg_raddr = ptr;
endmodule

// File: rtl/ibrs_chk.sv
module ibrs_chk #(
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 24,
  parameter int CNT_IDX  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_waddr
);
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  // R7
  strobe_range_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (32'(reg_waddr) < NUM_REGS));
  // R6
  strobe_not_len_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (32'(reg_waddr) != CNT_IDX));
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);
  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) && !$past(stop_det) && !$past(start_det) |-> !scl_s);
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sda_oe && !reg_we));
endmodule

bind idx_i2c_regslave ibrs_chk #(
  .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX)
) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr)
);

// File: tb/test_idx_i2c_regslave.sv
module test_idx_i2c_regslave;
  localparam int NUM = 24;
  localparam int LEN_IDX = 8;
  localparam int Q = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr, reg_rdata;
  logic sda_line;
  logic [7:0] env_mem [256];
  logic [7:0] shadow  [256];
  logic [7:0] len_model = 8'h0F;
  logic [15:0] exp_wr [$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = env_mem[reg_raddr];

  idx_i2c_regslave i_idx_i2c_regslave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // environment register file
  always @(posedge clk) if (reg_we) env_mem[reg_waddr] <= reg_wdata;

  // monitor: every strobe must match the next expected write (R2, R3, R7)
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      if (exp_wr.size() == 0) chk(0, "R2/R3 unexpected strobe", {reg_waddr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_wr.pop_front();
        chk({reg_waddr, reg_wdata} == e, "R2 write strobe", {reg_waddr, reg_wdata}, e);
      end
    end
  end

  task automatic hc(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; hc(2); scl_m = 1'b1; hc(Q); sda_m = 1'b0; hc(Q); scl_m = 1'b0; hc(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hc(2); scl_m = 1'b1; hc(Q); sda_m = 1'b1; hc(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hc(Q); scl_m = 1'b1; hc(Q); scl_m = 1'b0; hc(2);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hc(Q); scl_m = 1'b1; hc(Q/2); b = sda_line; hc(Q/2); scl_m = 1'b0; hc(2);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      d[i] = b;
    end
    put_bit(~master_ack);
  endtask

  // driver: block write, expected strobes pushed into the scoreboard
  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt,
                          input logic [7:0] d [8], input int nsend);
    logic a;
    bus_start;
    put_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    put_byte(idx, a);   chk(a, "R2 index ack", a, 1);
    put_byte(cnt, a);   chk(a, "R2 count ack", a, 1);
    for (int k = 0; k < nsend; k++) begin
      int ad;
      ad = (idx + k) & 255;
      if (k < cnt) begin
        if (ad == LEN_IDX) len_model = d[k];
        else if (ad < NUM) begin
          exp_wr.push_back({8'(ad), d[k]});
          shadow[ad] = d[k];
        end
      end
      put_byte(d[k], a);
      chk(a == (k < cnt), (k < cnt) ? "R2 data ack" : "R3 surplus byte nack", a, k < cnt);
      if (!a) break;
    end
    bus_stop;
    hc(4);
    chk(exp_wr.size() == 0, "R2/R7 all strobes seen", exp_wr.size(), 0);
  endtask

  // driver: indexed read, expected bytes computed from the model
  task automatic do_read(input logic [7:0] idx, input int nrd, input bit ack_last);
    logic a;
    logic [7:0] got, e;
    bus_start;
    put_byte(8'hD2, a); chk(a, "R1 write address ack", a, 1);
    put_byte(idx, a);   chk(a, "R4 index ack", a, 1);
    bus_start;
    put_byte(8'hD3, a); chk(a, "R1 read address ack", a, 1);
    get_byte(1'b1, got);
    chk(got == len_model, "R4/R6 length byte first", got, len_model);
    for (int k = 0; k < nrd; k++) begin
      int ad;
      ad = (idx + k) & 255;
      if (k >= len_model) e = 8'hFF;
      else if (ad == LEN_IDX) e = len_model;
      else if (ad < NUM) e = shadow[ad];
      else e = 8'h00;
      get_byte((k < nrd - 1) || ack_last, got);
      chk(got == e, (k >= len_model) ? "R9 released after last byte" :
                    (ad >= NUM) ? "R7 out-of-range reads zero" : "R4 read data", got, e);
    end
    bus_stop;
    hc(4);
    chk(!sda_oe, "R5 SDA released after stop", sda_oe, 0);
  endtask

  initial begin
    logic [7:0] d [8];
    logic a;
    for (int i = 0; i < 256; i++) begin env_mem[i] = 8'h00; shadow[i] = 8'h00; end
    hc(5);
    chk(!sda_oe && !reg_we, "R11 reset state", {sda_oe, reg_we}, 0);
    rst = 1'b0;
    hc(5);

    // multi-byte write then read back with early nack
    d = '{8'h11, 8'h22, 8'h33, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd2, 8'd3, d, 3);
    do_read(8'd2, 3, 1'b0);

    // foreign address: no ack, no strobes
    bus_start;
    put_byte(8'hA4, a); chk(!a, "R1 foreign address nack", a, 0);
    put_byte(8'h02, a); chk(!a, "R1 ignored after foreign address", a, 0);
    bus_stop;
    hc(4);

    // surplus data byte rejected
    d = '{8'h5A, 8'h6B, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd0, 8'd1, d, 2);

    // length register: write, then read past it and acknowledge the last byte
    d = '{8'h9C, 8'h02, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd7, 8'd2, d, 2);
    do_read(8'd7, 3, 1'b1);

    // top of bank and beyond
    d = '{8'h04, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd8, 8'd1, d, 1);
    d = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd22, 8'd4, d, 4);
    do_read(8'd22, 4, 1'b0);

    // zero length: only the length byte, then released
    d = '{8'h00, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd8, 8'd1, d, 1);
    do_read(8'd3, 1, 1'b1);

    // abort in the middle of a data byte
    bus_start;
    put_byte(8'hD2, a); put_byte(8'd5, a); put_byte(8'd3, a);
    exp_wr.push_back({8'd5, 8'h77}); shadow[5] = 8'h77;
    put_byte(8'h77, a); chk(a, "R8 byte before abort acked", a, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start;
    bus_stop;
    hc(4);
    chk(!sda_oe, "R8 released after abort", sda_oe, 0);
    chk(exp_wr.size() == 0, "R8 no extra strobe", exp_wr.size(), 0);
    d = '{8'h03, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    do_write(8'd8, 8'd1, d, 1);
    do_read(8'd4, 3, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule